// File: doc/BRIEF.md
# Thermometer-to-Gray Flash Encoder

This block sits behind a bank of 2^N−1 parallel comparators and turns their thermometer word into an N-bit output code. Instead of first finding the single 1-to-0 boundary, it builds each Gray bit directly as the parity of a fixed set of thermometer taps. Each comparator bit feeds exactly one Gray term. An isolated wrong comparator bit (a bubble), or one that settles late, can then flip at most one Gray bit. It never causes a jump of half the range.

A strobe marks the cycle in which the thermometer word is valid. On that clock edge the Gray code and the binary code derived from it are both captured into output registers. A valid flag reports the capture one clock later. When the strobe is low, both codes hold their last value.

Top module: `therm_gray_encoder`

## Requirements
- R1: While reset is asserted, and after its release until the first strobe, grayOut, binOut and validOut are all zero.
- R2: validOut is 1 in the cycle after a clock edge that sees strobeIn high, and 0 after an edge that sees it low.
- R3: A clock edge with strobeIn low leaves grayOut and binOut unchanged, whatever thermIn carries.
- R4: For a clean thermometer word (thermIn equal to 2^k−1, that is, ones only in bits 0..k−1), binOut after the capturing edge equals k.
- R5: grayOut always equals binOut XOR (binOut shifted right by one), so the output is the reflected Gray code of the binary result.
- R6: Gray bit k (bit 0 is the least significant) is the parity of the thermometer taps with 1-based index j whose lowest set bit is bit k. Port bit i of thermIn carries index j = i+1. Every tap belongs to exactly one Gray bit, and this holds for any input word, clean or not.
- R7: A clean word with exactly one bit inverted (a single bubble) yields a Gray code that differs from the clean word's Gray code in exactly one bit.
- R8: Clean words with counts k and k+1 give Gray codes that differ in exactly one bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| strobeIn | input | 1 | Capture thermIn on this edge |
| thermIn | input | 2^CODE_W−1 | Comparator outputs, bit 0 = lowest reference |
| grayOut | output | CODE_W | Registered Gray code |
| binOut | output | CODE_W | Registered binary code |
| validOut | output | 1 | Capture happened on the previous edge |

## Verification
The hardest case to reach is a corrupted thermometer word, because a real comparator bank rarely produces one on demand. The bench drives every single-bubble pattern directly. For each clean count it inverts each bit position in turn. It then checks that exactly one Gray bit differs from the clean result and that the result matches the tap-parity rule. Hold behaviour is checked by changing thermIn with the strobe low and confirming that both output codes are unchanged.

// File: rtl/therm_gray_pkg.sv
package therm_gray_pkg;
  // Strobes sent from the control module to the datapath.
  typedef struct packed {
    logic captureEn;  // load Gray and binary registers this edge
  } ctrlStrobe_t;
endpackage

// File: rtl/therm_tap_encoder.sv
module therm_tap_encoder #(
  parameter int CODE_W = 4,
  localparam int THERM_W = (1 << CODE_W) - 1
) (
  input  logic [THERM_W-1:0] thermIn,
  output logic [CODE_W-1:0]  grayComb
);
  // A tap with 1-based index j feeds Gray bit k when k is the lowest set bit of j.
  function automatic logic [THERM_W-1:0] tapMask(input int k);
    logic [THERM_W-1:0] m;
    m = '0;
    for (int j = 1; j <= THERM_W; j++) begin
      if ((j % (2 << k)) == (1 << k)) m[j-1] = 1'b1;
    end
    return m;
  endfunction

  for (genvar k = 0; k < CODE_W; k++) begin : gBit
    localparam logic [THERM_W-1:0] MASK = tapMask(k);
    assign grayComb[k] = ^(thermIn & MASK);
  end
endmodule

// File: rtl/gray_to_bin.sv
module gray_to_bin #(
  parameter int CODE_W = 4
) (
  input  logic [CODE_W-1:0] grayIn,
  output logic [CODE_W-1:0] binComb
);
  // Each binary bit is the parity of all Gray bits at or above its position.
  for (genvar k = 0; k < CODE_W; k++) begin : gBin
    assign binComb[k] = ^grayIn[CODE_W-1:k];
  end
endmodule

// File: rtl/therm_gray_ctrl.sv
module therm_gray_ctrl
  import therm_gray_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        strobeIn,
  output ctrlStrobe_t ctl,
  output logic        validOut
);
  logic validQ;

  always_comb ctl.captureEn = strobeIn;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) validQ <= 1'b0;
    else       validQ <= strobeIn;
  end

  assign validOut = validQ;

  AST_VALID_AFTER_STROBE: assert property (@(posedge clk) disable iff (!rstN)
    strobeIn |=> validOut); // R2
  AST_NO_VALID_WITHOUT_STROBE: assert property (@(posedge clk) disable iff (!rstN)
    !strobeIn |=> !validOut); // R2
endmodule

// File: rtl/therm_gray_datapath.sv
module therm_gray_datapath
  import therm_gray_pkg::*;
#(
  parameter int CODE_W = 4,
  localparam int THERM_W = (1 << CODE_W) - 1
) (
  input  logic               clk,
  input  logic               rstN,
  input  ctrlStrobe_t        ctl,
  input  logic [THERM_W-1:0] thermIn,
  output logic [CODE_W-1:0]  grayOut,
  output logic [CODE_W-1:0]  binOut
);
  localparam logic [THERM_W-1:0] ONE_T = 1;

  logic [CODE_W-1:0] grayComb;
  logic [CODE_W-1:0] binComb;
  logic [CODE_W-1:0] grayQ;
  logic [CODE_W-1:0] binQ;

  therm_tap_encoder #(.CODE_W(CODE_W)) uEnc (
    .thermIn (thermIn),
    .grayComb(grayComb)
  );

  gray_to_bin #(.CODE_W(CODE_W)) uG2b (
    .grayIn (grayComb),
    .binComb(binComb)
  );

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      grayQ <= '0;
      binQ  <= '0;
    end else if (ctl.captureEn) begin
      grayQ <= grayComb;
      binQ  <= binComb;
    end
  end

  assign grayOut = grayQ;
  assign binOut  = binQ;

  AST_HOLD_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    !ctl.captureEn |=> ($stable(grayQ) && $stable(binQ))); // R3
  AST_CLEAN_COUNT: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.captureEn && ((thermIn & (thermIn + ONE_T)) == '0))
      |=> (binQ == CODE_W'($countones($past(thermIn))))); // R4
  AST_REFLECTED_PAIR: assert property (@(posedge clk) disable iff (!rstN)
    grayQ == (binQ ^ (binQ >> 1))); // R5
endmodule

// File: rtl/therm_gray_encoder.sv
module therm_gray_encoder
  import therm_gray_pkg::*;
#(
  parameter int CODE_W = 4,
  localparam int THERM_W = (1 << CODE_W) - 1
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               strobeIn,
  input  logic [THERM_W-1:0] thermIn,
  output logic [CODE_W-1:0]  grayOut,
  output logic [CODE_W-1:0]  binOut,
  output logic               validOut
);
  ctrlStrobe_t ctl;

  therm_gray_ctrl uCtrl (
    .clk     (clk),
    .rstN    (rstN),
    .strobeIn(strobeIn),
    .ctl     (ctl),
    .validOut(validOut)
  );

  therm_gray_datapath #(.CODE_W(CODE_W)) uDp (
    .clk    (clk),
    .rstN   (rstN),
    .ctl    (ctl),
    .thermIn(thermIn),
    .grayOut(grayOut),
    .binOut (binOut)
  );
endmodule

// File: tb/tb_therm_gray_encoder.sv
`timescale 1ns/1ps
module tb_therm_gray_encoder;
  localparam int CODE_W = 4;
  localparam int THERM_W = 15;

  typedef struct packed {
    logic [THERM_W-1:0] therm;
    logic [CODE_W-1:0]  bin;
    logic [CODE_W-1:0]  gray;
  } vec_t;

  // Clean thermometer words for counts 0..15 with expected binary and Gray.
  localparam vec_t VECS [16] = '{
    '{15'h0000, 4'd0,  4'd0},  '{15'h0001, 4'd1,  4'd1},
    '{15'h0003, 4'd2,  4'd3},  '{15'h0007, 4'd3,  4'd2},
    '{15'h000F, 4'd4,  4'd6},  '{15'h001F, 4'd5,  4'd7},
    '{15'h003F, 4'd6,  4'd5},  '{15'h007F, 4'd7,  4'd4},
    '{15'h00FF, 4'd8,  4'd12}, '{15'h01FF, 4'd9,  4'd13},
    '{15'h03FF, 4'd10, 4'd15}, '{15'h07FF, 4'd11, 4'd14},
    '{15'h0FFF, 4'd12, 4'd10}, '{15'h1FFF, 4'd13, 4'd11},
    '{15'h3FFF, 4'd14, 4'd9},  '{15'h7FFF, 4'd15, 4'd8}
  };

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic strobeIn = 1'b0;
  logic [THERM_W-1:0] thermIn = '0;
  logic [CODE_W-1:0] grayOut;
  logic [CODE_W-1:0] binOut;
  logic validOut;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  therm_gray_encoder #(.CODE_W(CODE_W)) dut (
    .clk(clk), .rstN(rstN), .strobeIn(strobeIn), .thermIn(thermIn),
    .grayOut(grayOut), .binOut(binOut), .validOut(validOut)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // Parity over taps j with j mod 2^(k+1) == 2^k, from the tap rule.
  function automatic logic [CODE_W-1:0] refGray(input logic [THERM_W-1:0] t);
    logic [CODE_W-1:0] g;
    g = '0;
    for (int k = 0; k < CODE_W; k++)
      for (int j = 1; j <= THERM_W; j++)
        if ((j % (2 << k)) == (1 << k)) g[k] = g[k] ^ t[j-1];
    return g;
  endfunction

  // Drive one word with the strobe for one cycle; return at the next negedge.
  task automatic capture(input logic [THERM_W-1:0] t);
    @(negedge clk);
    thermIn = t;
    strobeIn = 1'b1;
    @(negedge clk);
    strobeIn = 1'b0;
  endtask

  initial begin
    logic [CODE_W-1:0] prevGray;
    logic [CODE_W-1:0] cleanGray;
    logic [THERM_W-1:0] bub;

    // R1: reset state
    repeat (3) @(negedge clk);
    check("R1 gray in reset", int'(grayOut), 0);
    check("R1 bin in reset", int'(binOut), 0);
    check("R1 valid in reset", int'(validOut), 0);
    rstN = 1'b1;
    thermIn = 15'h00FF;
    repeat (2) @(negedge clk);
    check("R1 gray after release", int'(grayOut), 0);
    check("R1 valid after release", int'(validOut), 0);

    // Table walk: R4, R5, R2, R8
    prevGray = '0;
    for (int i = 0; i < 16; i++) begin
      capture(VECS[i].therm);
      check("R2 valid after strobe", int'(validOut), 1);
      check("R4 clean count", int'(binOut), int'(VECS[i].bin));
      check("R5 gray code", int'(grayOut), int'(VECS[i].gray));
      check("R5 gray vs bin", int'(grayOut), int'(binOut ^ (binOut >> 1)));
      if (i > 0) check("R8 one bit step", $countones(grayOut ^ prevGray), 1);
      prevGray = grayOut;
      @(negedge clk);
      check("R2 valid drops", int'(validOut), 0);
    end

    // R3: inputs ignored with strobe low
    capture(15'h003F);
    @(negedge clk);
    thermIn = 15'h7FFF;
    repeat (3) @(negedge clk);
    check("R3 gray held", int'(grayOut), 5);
    check("R3 bin held", int'(binOut), 6);
    check("R3 valid low", int'(validOut), 0);

    // R6, R7: every single bubble on every clean word
    for (int i = 0; i < 16; i++) begin
      cleanGray = VECS[i].gray;
      for (int p = 0; p < THERM_W; p++) begin
        bub = VECS[i].therm ^ (15'h0001 << p);
        capture(bub);
        check("R7 bubble flips one gray bit", $countones(grayOut ^ cleanGray), 1);
        check("R6 tap parity", int'(grayOut), int'(refGray(bub)));
      end
    end

    // R6: arbitrary non-thermometer patterns
    capture(15'h5555);
    check("R6 pattern 5555", int'(grayOut), int'(refGray(15'h5555)));
    capture(15'h2AAA);
    check("R6 pattern 2AAA", int'(grayOut), int'(refGray(15'h2AAA)));
    check("R5 bin follows gray", int'(grayOut), int'(binOut ^ (binOut >> 1)));

    // Back-to-back strobes keep valid high (R2)
    @(negedge clk);
    thermIn = 15'h0007;
    strobeIn = 1'b1;
    @(negedge clk);
    thermIn = 15'h0FFF;
    check("R2 valid on first of pair", int'(validOut), 1);
    @(negedge clk);
    strobeIn = 1'b0;
    check("R2 valid on second of pair", int'(validOut), 1);
    check("R4 second of pair", int'(binOut), 12);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule